// File: doc/BRIEF.md
# Chained-Buffer DMA Channel

This block is one DMA channel that a processor steers through three 32-bit registers: a control/status word, an address and a byte count. The channel keeps two descriptor slots, a current one that the burst engine is working on and a next one that software fills while the current buffer is still moving. Software writes a count and then an address. The address write places the pair in the next slot. When the current buffer runs out, the next pair moves into the current slot without a gap, so buffers can follow each other back to back.

Toward memory the channel is a simple burst master. It raises `mem_req` with the live current address and holds it while the memory returns one `mem_ack` per 4-byte beat. Each burst has a programmable length, and `mem_last` marks the final beat of a burst. A burst starts only while the device raises `dev_req`. Completion, device interrupts and bus errors set sticky pending flags. Software clears them by writing ones, so writing back the word just read acknowledges every flag that was set. A soft reset lets any burst already in flight finish, then clears the channel, and software polls until the draining and cycle-pending flags read zero.

The burst engine is a state machine with four states. `ST_IDLE` waits and moves to `ST_BURST` when a burst can start, or to `ST_PURGE` on a reset request. `ST_BURST` issues beats and returns to `ST_IDLE` on the last beat or an error. A reset request moves it to `ST_DRAIN`, or straight to `ST_PURGE` if the request arrives on the closing beat. `ST_DRAIN` keeps issuing beats until the burst closes and then goes to `ST_PURGE`. `ST_PURGE` spends one cycle clearing the slots, flags and configuration, then goes back to `ST_IDLE`.

Top module: `cdma_channel`

## Requirements
- R1: After `rst_n` is released, the control word reads exactly the device identifier in bits 31:28 (default 5, so 0x5000_0000), and `irq` and `mem_req` are low.
- R2: The register is chosen by `reg_word`: 0 is the control word, 1 is the address and 2 is the count. The address reads the live current address and the count reads the remaining residue, zero-extended from 24 bits. Control-word bits are: 0 interrupt pending, 1 error pending, 2 draining, 4 interrupt enable, 7 reset (write only), 8 write direction, 9 DMA enable, 10 cycle pending, 13 count enable, 14 terminal count, 19:18 burst code, 23 completion-interrupt mask, 25 active (DMA enable and current slot loaded), 26 current slot loaded, 27 next slot loaded, 31:28 identifier.
- R3: A count write only stages the value. An address write moves the address and the staged count into the next slot and sets bit 27, but only while bit 9 is set and bit 27 is clear. Otherwise the address write is ignored.
- R4: While the current slot is empty and the next slot is loaded, the next pair becomes current on the following clock edge. Bit 26 then sets and bit 27 clears.
- R5: While bit 9 is set, the current slot is loaded and `dev_req` is high, the channel raises `mem_req` with `mem_addr` equal to the current address and `mem_we` equal to bit 8. A burst lasts the number of beats given by the burst code (00 gives 4, 01 gives 8, 10 gives 1, 11 gives 16) or ends earlier when the count runs out. `mem_last` is high on the final acknowledged beat.
- R6: Each acknowledged beat without error adds 4 to the address. With bit 13 set, it also lowers the count by 4, or to zero if fewer bytes remain.
- R7: When the count reaches zero, bit 14 sets and the current slot empties. Bit 0 also sets unless bit 23 is set.
- R8: A high `dev_irq` on a clock edge sets bit 0 and leaves bit 14 unchanged.
- R9: A beat acknowledged together with `mem_err` sets bit 1, ends the burst and drops the current buffer. That beat does not advance the address or the count.
- R10: Writing a one to bit 0, 1 or 14 of the control word clears that flag. Writing back the word just read clears every set flag and keeps the configuration bits.
- R11: `irq` is high exactly when bit 4 is set and bit 0 or bit 1 is set.
- R12: Writing bit 7 starts a soft reset and the other bits of that write are ignored. While a burst is in flight, bits 2 and 10 read one and the burst runs to its end. After that, both bits clear, the slots, address, count, flags and configuration all read zero, and no new burst starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_word | input | 2 | Register word index (byte offset / 4) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_word` |
| dev_req | input | 1 | Device request strobe that allows bursts |
| dev_irq | input | 1 | Device-originated interrupt event |
| mem_req | output | 1 | Burst request, held for the whole burst |
| mem_addr | output | 32 | Address of the current beat |
| mem_we | output | 1 | Transfer direction toward memory |
| mem_last | output | 1 | Current beat is the final beat of the burst |
| mem_ack | input | 1 | Beat acknowledge from memory |
| mem_err | input | 1 | Error on the acknowledged beat |
| irq | output | 1 | Interrupt request to the processor |

## Verification
Several buffer patterns are used. A first buffer of 16 bytes with 4-beat bursts is chained with a second of 8 bytes, and a third address write is refused. This shows whether the handover is gap-free and whether the one-deep next slot really refuses extra buffers. Single-beat bursts with the direction bit set and completion interrupts masked separate the terminal-count record from the interrupt flag. An 8-beat burst cut off by a bus error shows that the erroring beat does not advance the address or count. A 16-beat burst, held off by withheld acknowledges and then reset part way through, shows whether the reset waits for the burst to finish, whether the residue is correct at an intermediate point, and whether the channel is fully cleared afterwards.

// File: rtl/cdma_pkg.sv
package cdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_DRAIN = 2'd2,
        ST_PURGE = 2'd3
    } eng_state_t;

    // Register word indices (byte offset / 4)
    localparam logic [1:0] W_CTRL = 2'd0;
    localparam logic [1:0] W_ADDR = 2'd1;
    localparam logic [1:0] W_CNT  = 2'd2;

    // Control word bit positions
    localparam int B_INT_PEND = 0;
    localparam int B_ERR_PEND = 1;
    localparam int B_DRAIN    = 2;
    localparam int B_INT_EN   = 4;
    localparam int B_RESET    = 7;
    localparam int B_WR_DIR   = 8;
    localparam int B_DMA_EN   = 9;
    localparam int B_CYC      = 10;
    localparam int B_CNT_EN   = 13;
    localparam int B_TC       = 14;
    localparam int B_BURST_LO = 18;
    localparam int B_TCI_MASK = 23;
    localparam int B_ACTIVE   = 25;
    localparam int B_CUR_LD   = 26;
    localparam int B_NXT_LD   = 27;
    localparam int B_ID_LO    = 28;

    localparam int BEATS_W = 5;

    function automatic logic [BEATS_W-1:0] burst_beats(input logic [1:0] code);
        logic [BEATS_W-1:0] n;
        unique case (code)
            2'b00:   n = BEATS_W'(4);
            2'b01:   n = BEATS_W'(8);
            2'b10:   n = BEATS_W'(1);
            default: n = BEATS_W'(16);
        endcase
        return n;
    endfunction

endpackage

// File: rtl/cdma_desc.sv
module cdma_desc #(
    parameter int CW         = 24,
    parameter int BEAT_BYTES = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_wr,
    input  logic          addr_wr,
    input  logic [31:0]   wdata,
    input  logic          accept,
    input  logic          beat,
    input  logic          drop,
    input  logic          purge,
    input  logic          cnt_en,
    output logic [31:0]   cur_addr,
    output logic [CW-1:0] cur_cnt,
    output logic          cur_valid,
    output logic          nxt_valid,
    output logic          cnt_final,
    output logic          tc_evt
);

    localparam logic [CW-1:0] STEP   = CW'(BEAT_BYTES);
    localparam logic [31:0]   ASTEP  = 32'(BEAT_BYTES);

    logic [CW-1:0] stage_cnt;
    logic [CW-1:0] nxt_cnt;
    logic [31:0]   nxt_addr;
    logic          commit;
    logic          promote;

    assign commit    = addr_wr && accept && !nxt_valid;
    assign promote   = !cur_valid && nxt_valid;
    assign cnt_final = cnt_en && (cur_cnt <= STEP);
    assign tc_evt    = beat && cnt_final;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_cnt <= '0;
            nxt_cnt   <= '0;
            nxt_addr  <= '0;
            nxt_valid <= 1'b0;
            cur_cnt   <= '0;
            cur_addr  <= '0;
            cur_valid <= 1'b0;
        end else if (purge) begin
            stage_cnt <= '0;
            nxt_cnt   <= '0;
            nxt_addr  <= '0;
            nxt_valid <= 1'b0;
            cur_cnt   <= '0;
            cur_addr  <= '0;
            cur_valid <= 1'b0;
        end else begin
            if (cnt_wr) begin
                stage_cnt <= wdata[CW-1:0];
            end
            if (beat) begin
                cur_addr <= cur_addr + ASTEP;
                if (cnt_en) begin
                    cur_cnt <= cnt_final ? '0 : cur_cnt - STEP;
                end
                if (tc_evt) begin
                    cur_valid <= 1'b0;
                end
            end
            if (drop) begin
                cur_valid <= 1'b0;
            end
            if (promote) begin
                cur_addr  <= nxt_addr;
                cur_cnt   <= nxt_cnt;
                cur_valid <= 1'b1;
                nxt_valid <= 1'b0;
            end
            if (commit) begin
                nxt_addr  <= wdata;
                nxt_cnt   <= stage_cnt;
                nxt_valid <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/cdma_engine.sv
module cdma_engine
    import cdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [1:0] burst_code,
    input  logic       cnt_final,
    input  logic       ack,
    input  logic       err,
    input  logic       rst_req,
    output logic       mem_req,
    output logic       mem_last,
    output logic       beat,
    output logic       drop,
    output logic       purge,
    output logic       drain,
    output logic       cyc_pend
);

    eng_state_t         state_q, state_d;
    logic [BEATS_W-1:0] left_q;
    logic               in_burst;
    logic               closing;

    assign in_burst = (state_q == ST_BURST) || (state_q == ST_DRAIN);
    assign closing  = in_burst && ack && (mem_last || err);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (rst_req)  state_d = ST_PURGE;
                else if (go)  state_d = ST_BURST;
            end
            ST_BURST: begin
                if (closing)      state_d = rst_req ? ST_PURGE : ST_IDLE;
                else if (rst_req) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (closing) state_d = ST_PURGE;
            end
            ST_PURGE: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_BURST) begin
                left_q <= burst_beats(burst_code);
            end else if (in_burst && ack) begin
                left_q <= left_q - BEATS_W'(1);
            end
        end
    end

    always_comb begin
        mem_req  = in_burst;
        mem_last = in_burst && ((left_q == BEATS_W'(1)) || cnt_final);
        beat     = in_burst && ack && !err;
        drop     = in_burst && ack && err;
        purge    = (state_q == ST_PURGE);
        drain    = (state_q == ST_DRAIN) || (state_q == ST_PURGE);
        cyc_pend = in_burst;
    end

endmodule

// File: rtl/cdma_channel.sv
module cdma_channel
    import cdma_pkg::*;
#(
    parameter int         CW         = 24,
    parameter int         BEAT_BYTES = 4,
    parameter logic [3:0] DEV_ID     = 4'h5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [1:0]  reg_word,
    input  logic        reg_wr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    input  logic        dev_req,
    input  logic        dev_irq,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    output logic        mem_we,
    output logic        mem_last,
    input  logic        mem_ack,
    input  logic        mem_err,
    output logic        irq
);

    localparam int PAD_W = 32 - CW;

    logic          wr_ctrl, wr_addr, wr_cnt, rst_req;
    logic          int_en, wr_dir, dma_en, cnt_en, tci_mask;
    logic [1:0]    burst_code;
    logic          int_pend, err_pend, tc_flag;
    logic [31:0]   cur_addr;
    logic [CW-1:0] cur_cnt;
    logic          cur_valid, nxt_valid, cnt_final, tc_evt;
    logic          beat, drop, purge, drain, cyc_pend, go;
    logic [31:0]   ctrl_word;

    assign wr_ctrl = reg_wr && (reg_word == W_CTRL);
    assign wr_addr = reg_wr && (reg_word == W_ADDR);
    assign wr_cnt  = reg_wr && (reg_word == W_CNT);
    assign rst_req = wr_ctrl && reg_wdata[B_RESET];
    assign go      = dma_en && cur_valid && dev_req && ((cur_cnt != '0) || !cnt_en);

    cdma_desc #(.CW(CW), .BEAT_BYTES(BEAT_BYTES)) i_desc (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_wr    (wr_cnt),
        .addr_wr   (wr_addr),
        .wdata     (reg_wdata),
        .accept    (dma_en),
        .beat      (beat),
        .drop      (drop),
        .purge     (purge),
        .cnt_en    (cnt_en),
        .cur_addr  (cur_addr),
        .cur_cnt   (cur_cnt),
        .cur_valid (cur_valid),
        .nxt_valid (nxt_valid),
        .cnt_final (cnt_final),
        .tc_evt    (tc_evt)
    );

    cdma_engine i_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (go),
        .burst_code (burst_code),
        .cnt_final  (cnt_final),
        .ack        (mem_ack),
        .err        (mem_err),
        .rst_req    (rst_req),
        .mem_req    (mem_req),
        .mem_last   (mem_last),
        .beat       (beat),
        .drop       (drop),
        .purge      (purge),
        .drain      (drain),
        .cyc_pend   (cyc_pend)
    );

    // Configuration and sticky flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_en     <= 1'b0;
            wr_dir     <= 1'b0;
            dma_en     <= 1'b0;
            cnt_en     <= 1'b0;
            tci_mask   <= 1'b0;
            burst_code <= 2'b00;
            int_pend   <= 1'b0;
            err_pend   <= 1'b0;
            tc_flag    <= 1'b0;
        end else if (purge) begin
            int_en     <= 1'b0;
            wr_dir     <= 1'b0;
            dma_en     <= 1'b0;
            cnt_en     <= 1'b0;
            tci_mask   <= 1'b0;
            burst_code <= 2'b00;
            int_pend   <= 1'b0;
            err_pend   <= 1'b0;
            tc_flag    <= 1'b0;
        end else begin
            if (wr_ctrl && !reg_wdata[B_RESET]) begin
                int_en     <= reg_wdata[B_INT_EN];
                wr_dir     <= reg_wdata[B_WR_DIR];
                dma_en     <= reg_wdata[B_DMA_EN];
                cnt_en     <= reg_wdata[B_CNT_EN];
                tci_mask   <= reg_wdata[B_TCI_MASK];
                burst_code <= reg_wdata[B_BURST_LO +: 2];
            end
            int_pend <= (int_pend && !(wr_ctrl && reg_wdata[B_INT_PEND]))
                        || dev_irq || (tc_evt && !tci_mask);
            err_pend <= (err_pend && !(wr_ctrl && reg_wdata[B_ERR_PEND])) || drop;
            tc_flag  <= (tc_flag && !(wr_ctrl && reg_wdata[B_TC])) || tc_evt;
        end
    end

    always_comb begin
        ctrl_word                     = '0;
        ctrl_word[B_INT_PEND]         = int_pend;
        ctrl_word[B_ERR_PEND]         = err_pend;
        ctrl_word[B_DRAIN]            = drain;
        ctrl_word[B_INT_EN]           = int_en;
        ctrl_word[B_WR_DIR]           = wr_dir;
        ctrl_word[B_DMA_EN]           = dma_en;
        ctrl_word[B_CYC]              = cyc_pend;
        ctrl_word[B_CNT_EN]           = cnt_en;
        ctrl_word[B_TC]               = tc_flag;
        ctrl_word[B_BURST_LO +: 2]    = burst_code;
        ctrl_word[B_TCI_MASK]         = tci_mask;
        ctrl_word[B_ACTIVE]           = dma_en && cur_valid;
        ctrl_word[B_CUR_LD]           = cur_valid;
        ctrl_word[B_NXT_LD]           = nxt_valid;
        ctrl_word[B_ID_LO +: 4]       = DEV_ID;
    end

    always_comb begin
        unique case (reg_word)
            W_CTRL:  reg_rdata = ctrl_word;
            W_ADDR:  reg_rdata = cur_addr;
            W_CNT:   reg_rdata = {{PAD_W{1'b0}}, cur_cnt};
            default: reg_rdata = '0;
        endcase
    end

    assign mem_addr = cur_addr;
    assign mem_we   = wr_dir;
    assign irq      = int_en && (int_pend || err_pend);

endmodule

// File: rtl/cdma_channel_chk.sv
module cdma_channel_chk #(
    parameter int CW         = 24,
    parameter int BEAT_BYTES = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dev_irq,
    input logic          int_en,
    input logic          irq,
    input logic          drain,
    input logic          cyc_pend,
    input logic          cur_valid,
    input logic          nxt_valid,
    input logic          purge,
    input logic          beat,
    input logic          cnt_en,
    input logic [CW-1:0] cur_cnt,
    input logic          mem_req,
    input logic          mem_ack,
    input logic          mem_err,
    input logic [31:0]   mem_addr,
    input logic          err_pend,
    input logic          tc_evt,
    input logic          tc_flag
);

    p_promote_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cur_valid && nxt_valid && !purge) |=> (cur_valid && !nxt_valid));

    p_req_loaded_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> cur_valid);

    p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        beat |=> (mem_addr == $past(mem_addr) + 32'(BEAT_BYTES)));

    p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (beat && cnt_en && cur_cnt != '0) |=> (cur_cnt < $past(cur_cnt)));

    p_tc_record_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tc_evt |=> tc_flag);

    p_dev_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_irq && int_en && !purge) |=> irq);

    p_err_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_err) |=> (err_pend && !mem_req));

    p_no_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (drain && !cyc_pend) |=> !cyc_pend);

    p_purge_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        purge |=> (!cur_valid && !nxt_valid && !err_pend));

endmodule

bind cdma_channel cdma_channel_chk #(.CW(CW), .BEAT_BYTES(BEAT_BYTES)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_irq   (dev_irq),
    .int_en    (int_en),
    .irq       (irq),
    .drain     (drain),
    .cyc_pend  (cyc_pend),
    .cur_valid (cur_valid),
    .nxt_valid (nxt_valid),
    .purge     (purge),
    .beat      (beat),
    .cnt_en    (cnt_en),
    .cur_cnt   (cur_cnt),
    .mem_req   (mem_req),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err),
    .mem_addr  (mem_addr),
    .err_pend  (err_pend),
    .tc_evt    (tc_evt),
    .tc_flag   (tc_flag)
);

// File: tb/test_cdma_channel.sv
module test_cdma_channel;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] ID      = 32'h5000_0000;
    localparam logic [31:0] F_INT   = 32'h1;
    localparam logic [31:0] F_ERR   = 32'h2;
    localparam logic [31:0] F_DRN   = 32'h4;
    localparam logic [31:0] C_IEN   = 32'h10;
    localparam logic [31:0] C_RST   = 32'h80;
    localparam logic [31:0] C_WDIR  = 32'h100;
    localparam logic [31:0] C_EN    = 32'h200;
    localparam logic [31:0] F_CYC   = 32'h400;
    localparam logic [31:0] C_CEN   = 32'h2000;
    localparam logic [31:0] F_TC    = 32'h4000;
    localparam logic [31:0] C_TCIM  = 32'h80_0000;
    localparam logic [31:0] S_ACT   = 32'h200_0000;
    localparam logic [31:0] S_CUR   = 32'h400_0000;
    localparam logic [31:0] S_NXT   = 32'h800_0000;

    typedef struct packed {
        logic [31:0] a;
        logic        last;
        logic        we;
    } beat_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_word = 2'd0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        dev_req = 1'b0;
    logic        dev_irq = 1'b0;
    logic        mem_req, mem_we, mem_last, mem_ack, mem_err, irq;
    logic [31:0] mem_addr;
    logic        ack_en = 1'b1;
    logic        err_en = 1'b0;
    logic        done = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    beat_t exp_q[$];

    assign mem_ack = mem_req && ack_en;
    assign mem_err = mem_req && err_en;

    always #(CLK_PERIOD/2) clk = ~clk;

    cdma_channel i_cdma_channel (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_word  (reg_word),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .dev_req   (dev_req),
        .dev_irq   (dev_irq),
        .mem_req   (mem_req),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_last  (mem_last),
        .mem_ack   (mem_ack),
        .mem_err   (mem_err),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] w, input logic [31:0] d);
        @(negedge clk);
        reg_word  = w;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] w, output logic [31:0] d);
        reg_word = w;
        #1;
        d = reg_rdata;
    endtask

    task automatic push(input logic [31:0] a, input logic last, input logic we);
        beat_t b;
        b.a = a; b.last = last; b.we = we;
        exp_q.push_back(b);
    endtask

    task automatic wait_req();
        while (!mem_req) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Monitor: compares every acknowledged beat with the scoreboard queue
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (rst_n && mem_req && mem_ack) begin
                if (exp_q.size() == 0) begin
                    n_chk++;
                    n_bad++;
                    $display("FAIL R5: actual beat at %h expected no beat", mem_addr);
                end else begin
                    beat_t e;
                    e = exp_q.pop_front();
                    chk("R5 beat address", mem_addr, e.a);
                    chk("R5 last marker", {31'd0, mem_last}, {31'd0, e.last});
                    chk("R5 direction", {31'd0, mem_we}, {31'd0, e.we});
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] cfg_a, cfg_b, cfg_c, cfg_d;
        cfg_a = C_IEN | C_EN | C_CEN;
        cfg_b = cfg_a | C_TCIM | (32'd2 << 18) | C_WDIR;
        cfg_c = cfg_a | (32'd1 << 18);
        cfg_d = cfg_a | (32'd3 << 18);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(2'd0, v);
        chk("R1 reset control word", v, ID);
        chk("R1 irq low", {31'd0, irq}, 32'd0);
        chk("R1 mem_req low", {31'd0, mem_req}, 32'd0);

        // Commit into next slot, then promotion
        wr(2'd0, cfg_a);
        wr(2'd2, 32'd16);
        wr(2'd1, 32'h1000);
        rd(2'd0, v);
        chk("R3 next slot loaded", v, ID | cfg_a | S_NXT);
        @(negedge clk);
        rd(2'd0, v);
        chk("R4 promoted to current", v, ID | cfg_a | S_CUR | S_ACT);
        rd(2'd1, v);
        chk("R2 address readback", v, 32'h1000);
        rd(2'd2, v);
        chk("R2 count readback", v, 32'd16);

        // Chain a second buffer; third address write must be refused
        wr(2'd2, 32'd8);
        wr(2'd1, 32'h2000);
        wr(2'd1, 32'h3000);
        push(32'h1000, 1'b0, 1'b0);
        push(32'h1004, 1'b0, 1'b0);
        push(32'h1008, 1'b0, 1'b0);
        push(32'h100C, 1'b1, 1'b0);
        push(32'h2000, 1'b0, 1'b0);
        push(32'h2004, 1'b1, 1'b0);
        @(negedge clk);
        dev_req = 1'b1;
        repeat (30) @(negedge clk);
        chk("R3 refused third buffer, queue drained", exp_q.size(), 0);
        rd(2'd0, v);
        chk("R7 terminal count and interrupt", v, ID | cfg_a | F_INT | F_TC);
        chk("R11 irq with pending", {31'd0, irq}, 32'd1);
        rd(2'd2, v);
        chk("R6 residue zero", v, 32'd0);
        rd(2'd1, v);
        chk("R6 address advanced", v, 32'h2008);

        // Write back to acknowledge
        rd(2'd0, v);
        wr(2'd0, v);
        rd(2'd0, v);
        chk("R10 write-back clears flags", v, ID | cfg_a);
        chk("R11 irq low after clear", {31'd0, irq}, 32'd0);

        // Device interrupt
        @(negedge clk);
        dev_irq = 1'b1;
        @(negedge clk);
        dev_irq = 1'b0;
        rd(2'd0, v);
        chk("R8 device interrupt", v, ID | cfg_a | F_INT);
        chk("R11 irq on device interrupt", {31'd0, irq}, 32'd1);
        wr(2'd0, (cfg_a & ~C_IEN) | F_INT);
        @(negedge clk);
        dev_irq = 1'b1;
        @(negedge clk);
        dev_irq = 1'b0;
        rd(2'd0, v);
        chk("R8 pending with enable off", v, ID | (cfg_a & ~C_IEN) | F_INT);
        chk("R11 irq masked by enable", {31'd0, irq}, 32'd0);
        wr(2'd0, cfg_a | F_INT);
        rd(2'd0, v);
        chk("R10 one clears pending", v, ID | cfg_a);

        // Masked completion, single-beat bursts, write direction
        wr(2'd0, cfg_b);
        push(32'h6000, 1'b1, 1'b1);
        push(32'h6004, 1'b1, 1'b1);
        wr(2'd2, 32'd8);
        wr(2'd1, 32'h6000);
        repeat (15) @(negedge clk);
        chk("R5 single-beat bursts done", exp_q.size(), 0);
        rd(2'd0, v);
        chk("R7 masked completion records tc only", v, ID | cfg_b | F_TC);
        chk("R7 no irq when masked", {31'd0, irq}, 32'd0);
        wr(2'd0, cfg_b | F_TC);
        rd(2'd0, v);
        chk("R10 tc cleared", v, ID | cfg_b);

        // Bus error on third beat of an 8-beat burst
        wr(2'd0, cfg_c);
        ack_en = 1'b0;
        wr(2'd2, 32'd32);
        wr(2'd1, 32'h7000);
        wait_req();
        push(32'h7000, 1'b0, 1'b0);
        push(32'h7004, 1'b0, 1'b0);
        push(32'h7008, 1'b0, 1'b0);
        ack_en = 1'b1;
        repeat (2) @(negedge clk);
        err_en = 1'b1;
        @(negedge clk);
        err_en = 1'b0;
        ack_en = 1'b0;
        repeat (5) @(negedge clk);
        rd(2'd0, v);
        chk("R9 error pending, buffer dropped", v, ID | cfg_c | F_ERR);
        chk("R11 irq on error", {31'd0, irq}, 32'd1);
        rd(2'd1, v);
        chk("R9 error beat not counted", v, 32'h7008);

        // Address write ignored while DMA enable is clear
        wr(2'd0, (cfg_a & ~C_EN) | F_ERR);
        wr(2'd2, 32'd4);
        wr(2'd1, 32'h8000);
        rd(2'd0, v);
        chk("R3 refused when disabled", v, ID | (cfg_a & ~C_EN));

        // Soft reset during a 16-beat burst
        wr(2'd0, cfg_d);
        for (int i = 0; i < 16; i++) begin
            push(32'h4000 + 32'(i * 4), (i == 15), 1'b0);
        end
        wr(2'd2, 32'd64);
        wr(2'd1, 32'h4000);
        wait_req();
        rd(2'd0, v);
        chk("R12 cycle pending during burst", v, ID | cfg_d | F_CYC | S_ACT | S_CUR);
        ack_en = 1'b1;
        repeat (3) @(negedge clk);
        ack_en = 1'b0;
        rd(2'd1, v);
        chk("R6 mid-burst address", v, 32'h400C);
        rd(2'd2, v);
        chk("R6 mid-burst residue", v, 32'd52);
        wr(2'd0, C_RST);
        rd(2'd0, v);
        chk("R12 draining with burst in flight", v, ID | cfg_d | F_DRN | F_CYC | S_ACT | S_CUR);
        ack_en = 1'b1;
        repeat (20) @(negedge clk);
        ack_en = 1'b0;
        chk("R12 burst ran to its end", exp_q.size(), 0);
        rd(2'd0, v);
        chk("R12 channel cleared", v, ID);
        rd(2'd1, v);
        chk("R12 address cleared", v, 32'd0);
        rd(2'd2, v);
        chk("R12 count cleared", v, 32'd0);
        chk("R12 irq low after reset", {31'd0, irq}, 32'd0);
        repeat (10) @(negedge clk);
        chk("R12 no burst after reset", {31'd0, mem_req}, 32'd0);

        done = 1'b1;
        finish_run();
    end

endmodule